// File: doc/BRIEF.md
# Third-Order Decimating Filter for a One-Bit Modulator Stream

This block turns the single-bit output of a delta-sigma modulator into signed 24-bit conversion results. The modulator bit is taken once every 32 system clocks. Three cascaded integrators run at that sample rate. Every 520 samples, which is one result per 16640 clocks, three differentiators at the decimated rate complete the third-order sinc response. The full-resolution difference is shifted right by four bits and clipped to the 24-bit two's complement range. The result is then presented for one cycle together with a valid strobe.

A synchronous clear is raised by the surrounding logic whenever the measured input is switched. The clear empties every integrator and differentiator, and it restarts the sample and decimation counters. The valid strobe stays low until the filter holds only data taken after the clear, so no partly settled result is ever flagged. If the input changes without a clear, the block keeps converting, and the results move through their transition until three full periods have passed.

Top module: `sinc3_decim`

## Requirements
- R1: While `rst_n` is low, and on the cycle after any clock edge with `clr_i` high, `vld_o` is 0 and `data_o` is 0.
- R2: `mod_i` is taken only on the 32nd rising edge after the clear edge, and on every 32nd edge after that. Its value on all other edges has no effect on any result.
- R3: A decimation happens on the edge that takes sample number 520·k after a clear. When a result is flagged, `vld_o` is high for exactly the one cycle after that edge, and flagged results are 16640 clocks apart.
- R4: A bit of 1 counts as +1 and a bit of 0 counts as −1. The full-resolution value is Σ w[j]·x[n−j] for j = 0 … 1557, where w holds the coefficients of (1+z⁻¹+…+z⁻⁵¹⁹)³ and x[n] is the newest sample. `data_o` is that value shifted arithmetically right by 4 (rounding toward −∞).
- R5: A shifted value above 8388607 gives `data_o` = 7FFFFFh. A shifted value below −8388608 gives 800000h.
- R6: After a clear, the first and second decimations are not flagged. The third decimation and every later one are flagged.
- R7: When the input density changes without a clear, results stay flagged and follow R4. From the third decimation whose window holds only new samples, the result equals the steady value of the new density.
- R8: A clear in the middle of a conversion discards the partial conversion. The timing of R3 and R6 restarts from that clear edge.
- R9: Outside a clear, `data_o` changes only on a cycle where `vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous filter clear, raised when the input is switched |
| mod_i | input | 1 | Modulator bitstream, 1 = +1, 0 = −1 |
| vld_o | output | 1 | One-cycle strobe marking a settled result |
| data_o | output | 24 | Signed conversion result, held between strobes |

## Verification
A constant stream of ones must drive the positive full-scale result into clipping. A constant stream of zeros, sent after a clear in the middle of a conversion, must give the negative limit, and it also checks the restart of the settling count. A repeating eight-sample pattern with five ones is applied without a clear straight after the all-ones stream. It shows the transitional results against a behavioural convolution and then the exact unclipped value of 2197000. Throughout the run, the bit driven on every non-sampling edge is the opposite of the intended sample, so a filter that samples on the wrong edge gives visibly wrong values.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  // Accumulator width: enough bits for the product of the decimation ratio
  // ORDER times, plus sign.
  function automatic int acc_bits(input int dec, input int order);
    return order * $clog2(dec) + 1;
  endfunction

  // Magnitude bits of the full-resolution DC gain dec**order.
  function automatic int gain_bits(input int dec, input int order);
    longint g;
    g = 1;
    for (int i = 0; i < order; i++) g = g * dec;
    return $clog2(g);
  endfunction

endpackage

// File: rtl/sinc3_tick.sv
// Sample-rate and decimation-rate enables plus settle tracking.
module sinc3_tick #(
  parameter int OSR_CLK = 32,
  parameter int DEC     = 520,
  parameter int ORDER   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic samp_o,
  output logic decim_o,
  output logic fire_o
);
  localparam int PH_W = $clog2(OSR_CLK);
  localparam int DC_W = $clog2(DEC);
  localparam int ST_W = $clog2(ORDER + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR_CLK - 1);
  localparam logic [DC_W-1:0] DC_LAST = DC_W'(DEC - 1);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(ORDER - 1);

  logic [PH_W-1:0] ph_q, ph_n;
  logic [DC_W-1:0] dc_q, dc_n;
  logic [ST_W-1:0] st_q, st_n;
  logic samp, decim;

  always_comb begin
    samp  = (ph_q == PH_LAST);
    decim = samp && (dc_q == DC_LAST);
    ph_n  = samp ? '0 : ph_q + 1'b1;
    dc_n  = dc_q;
    if (samp) dc_n = decim ? '0 : dc_q + 1'b1;
    st_n  = st_q;
    if (decim && (st_q != ST_LAST)) st_n = st_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      dc_q <= '0;
      st_q <= '0;
    end else if (clr_i) begin
      ph_q <= '0;
      dc_q <= '0;
      st_q <= '0;
    end else begin
      ph_q <= ph_n;
      dc_q <= dc_n;
      st_q <= st_n;
    end
  end

  assign samp_o  = samp;
  assign decim_o = decim;
  assign fire_o  = decim && (st_q == ST_LAST);
endmodule

// File: rtl/sinc3_integ.sv
// Cascade of integrators, updated once per modulator sample.
// The chain is combinational, so the last stage's new value is ready on the same edge.
module sinc3_integ #(
  parameter int ACC_W = 31,
  parameter int ORDER = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    bit_i,
  output logic signed [ACC_W-1:0] sum_o
);
  localparam logic signed [ACC_W-1:0] STEP_UP = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] STEP_DN = {ACC_W{1'b1}};

  logic signed [ACC_W-1:0] chain [ORDER+1];
  logic signed [ACC_W-1:0] acc_q [ORDER];
  logic signed [ACC_W-1:0] acc_n [ORDER];

  assign chain[0] = bit_i ? STEP_UP : STEP_DN;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    assign chain[g+1] = acc_q[g] + chain[g];
    assign acc_n[g]   = en_i ? chain[g+1] : acc_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q[g] <= '0;
      else if (clr_i) acc_q[g] <= '0;
      else            acc_q[g] <= acc_n[g];
    end
  end

  assign sum_o = chain[ORDER];
endmodule

// File: rtl/sinc3_comb.sv
// Cascade of differentiators at the decimated rate.
module sinc3_comb #(
  parameter int ACC_W = 31,
  parameter int ORDER = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] in_i,
  output logic signed [ACC_W-1:0] diff_o
);
  logic signed [ACC_W-1:0] c [ORDER+1];
  logic signed [ACC_W-1:0] z_q [ORDER];
  logic signed [ACC_W-1:0] z_n [ORDER];

  assign c[0] = in_i;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    assign c[g+1] = c[g] - z_q[g];
    assign z_n[g] = en_i ? c[g] : z_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     z_q[g] <= '0;
      else if (clr_i) z_q[g] <= '0;
      else            z_q[g] <= z_n[g];
    end
  end

  assign diff_o = c[ORDER];
endmodule

// File: rtl/sinc3_trim.sv
// Scale by an arithmetic right shift, then clip to the signed output range.
module sinc3_trim #(
  parameter int IN_W  = 31,
  parameter int SHIFT = 4,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0] val_i,
  output logic [OUT_W-1:0]       q_o
);
  logic signed [IN_W-1:0] sh;
  assign sh = val_i >>> SHIFT;

  if (IN_W - SHIFT <= OUT_W) begin : g_fits
    assign q_o = sh[OUT_W-1:0];
  end else begin : g_clip
    localparam logic signed [IN_W-1:0] HI = IN_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [IN_W-1:0] LO = ~HI;
    always_comb begin
      if (sh > HI)      q_o = HI[OUT_W-1:0];
      else if (sh < LO) q_o = LO[OUT_W-1:0];
      else              q_o = sh[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int OSR_CLK = 32,
  parameter int DEC     = 520,
  parameter int ORDER   = 3,
  parameter int OUT_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             mod_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] data_o
);
  localparam int ACC_W = sinc3_pkg::acc_bits(DEC, ORDER);
  localparam int GAIN  = sinc3_pkg::gain_bits(DEC, ORDER);
  localparam int SHIFT = (GAIN > OUT_W) ? GAIN - OUT_W : 0;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic samp, decim, fire;
  logic signed [ACC_W-1:0] integ_sum, comb_diff;
  logic [OUT_W-1:0] trimmed;

  sinc3_tick #(.OSR_CLK(OSR_CLK), .DEC(DEC), .ORDER(ORDER)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .clr_i(clr_i),
    .samp_o(samp), .decim_o(decim), .fire_o(fire)
  );

  sinc3_integ #(.ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk(clk), .rst_n(rst_int_n), .clr_i(clr_i), .en_i(samp),
    .bit_i(mod_i), .sum_o(integ_sum)
  );

  sinc3_comb #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk(clk), .rst_n(rst_int_n), .clr_i(clr_i), .en_i(decim),
    .in_i(integ_sum), .diff_o(comb_diff)
  );

  sinc3_trim #(.IN_W(ACC_W), .SHIFT(SHIFT), .OUT_W(OUT_W)) u_trim (
    .val_i(comb_diff), .q_o(trimmed)
  );

  logic [OUT_W-1:0] data_q, data_n;
  logic             vld_q, vld_n;

  always_comb begin
    vld_n  = fire;
    data_n = fire ? trimmed : data_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (clr_i) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_n;
      data_q <= data_n;
    end
  end

  assign vld_o  = vld_q;
  assign data_o = data_q;
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int OSR_CLK = 32,
  parameter int DEC     = 520,
  parameter int ORDER   = 3,
  parameter int OUT_W   = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             vld_o,
  input logic [OUT_W-1:0] data_o
);
  localparam int PERIOD = OSR_CLK * DEC;
  localparam int SETTLE = ORDER * PERIOD;

  int  since_q;
  int  gap_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= 0;
      gap_q   <= 0;
      seen_q  <= 1'b0;
    end else if (clr_i) begin
      since_q <= 0;
      gap_q   <= 0;
      seen_q  <= 1'b0;
    end else begin
      if (since_q < SETTLE) since_q <= since_q + 1;
      if (vld_o) begin
        gap_q  <= 1;
        seen_q <= 1'b1;
      end else if (gap_q <= PERIOD) begin
        gap_q <= gap_q + 1;
      end
    end
  end

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!vld_o && data_o == '0)); // R1

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o); // R3

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && seen_q) |-> (gap_q == PERIOD)); // R3

  AST_SETTLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (since_q >= SETTLE)); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (vld_o || $stable(data_o))); // R9
endmodule

bind sinc3_decim sinc3_decim_chk #(
  .OSR_CLK(OSR_CLK), .DEC(DEC), .ORDER(ORDER), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .vld_o(vld_o), .data_o(data_o)
);

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;
  localparam int CLK_P  = 10;
  localparam int OSR    = 32;
  localparam int DEC    = 520;
  localparam int PERIOD = OSR * DEC;
  localparam int KLEN   = 3 * DEC - 2;
  localparam int WD_CYC = 190000;

  logic        clk = 1'b0;
  logic        rst_n, clr_i, mod_i;
  logic        vld_o;
  logic [23:0] data_o;

  always #(CLK_P / 2) clk = ~clk;

  sinc3_decim u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .mod_i(mod_i),
    .vld_o(vld_o), .data_o(data_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int b2 [2*DEC-1];
  int w  [KLEN];
  int q  [$];
  int ph, nsamp, k, gidx;
  bit exp_vld;
  int cur_data;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic bit pat(input int mode, input int idx);
    case (mode)
      0:       return 1'b1;
      1:       return 1'b0;
      default: return (idx % 8) < 5;
    endcase
  endfunction

  // Behavioural convolution with the sinc3 kernel (R4), then shift and clip (R5).
  function automatic int model();
    longint acc = 0;
    for (int j = 0; j < KLEN; j++) acc += longint'(w[j]) * q[q.size() - 1 - j];
    acc = acc >>> 4;
    if (acc > 8388607) acc = 8388607;
    if (acc < -8388608) acc = -8388608;
    return int'(acc);
  endfunction

  // One clock: compare what the last edge produced, then drive the next edge.
  task automatic step(input int mode, input bit do_clr, input string tag);
    bit b;
    @(negedge clk);
    check(vld_o === exp_vld, {tag, " R2 R3 R6 valid strobe"}, int'(vld_o), int'(exp_vld));
    check(data_o === 24'(cur_data), {tag, " R4 R9 data"}, int'($signed(data_o)), cur_data);
    clr_i = do_clr;
    if (do_clr) begin
      q.delete();
      ph = 0; nsamp = 0; k = 0;
      exp_vld = 1'b0;
      cur_data = 0;
      mod_i = 1'b0;
    end else begin
      b = pat(mode, gidx);
      exp_vld = 1'b0;
      if (ph == OSR - 1) begin
        mod_i = b;
        q.push_back(b ? 1 : -1);
        if (q.size() > KLEN) void'(q.pop_front());
        nsamp++;
        gidx++;
        if (nsamp % DEC == 0) begin
          k++;
          if (k >= 3) begin
            exp_vld = 1'b1;
            cur_data = model();
          end
        end
      end else begin
        // R2: the opposite bit on non-sampling edges must not matter
        mod_i = ~b;
      end
      ph = (ph + 1) % OSR;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2*DEC-1; i++) b2[i] = 0;
    for (int i = 0; i < KLEN; i++) w[i] = 0;
    for (int a = 0; a < DEC; a++)
      for (int c = 0; c < DEC; c++) b2[a+c]++;
    for (int a = 0; a < 2*DEC-1; a++)
      for (int c = 0; c < DEC; c++) w[a+c] += b2[a];

    rst_n = 1'b0; clr_i = 1'b0; mod_i = 1'b0;
    ph = 0; nsamp = 0; k = 0; gidx = 0; exp_vld = 1'b0; cur_data = 0;

    repeat (3) begin
      @(negedge clk);
      check(vld_o === 1'b0 && data_o === 24'd0, "R1 reset state", int'(data_o), 0);
    end
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(vld_o === 1'b0 && data_o === 24'd0, "R1 after release", int'(data_o), 0);
    end

    // All ones after a clear: positive clip at the third decimation
    step(0, 1'b1, "R1 clear");
    for (int i = 0; i < 3 * PERIOD + 4; i++) step(0, 1'b0, "R5 positive clip");
    check(data_o === 24'h7FFFFF, "R5 positive limit", int'($signed(data_o)), 8388607);

    // Five-of-eight density without a clear: transition, then the steady value
    for (int i = 0; i < 3 * PERIOD; i++) step(2, 1'b0, "R7 change without clear");
    check(data_o === 24'd2197000, "R7 R4 settled value", int'($signed(data_o)), 2197000);

    // Clear in the middle of a conversion, then all zeros: negative clip
    for (int i = 0; i < 8000; i++) step(2, 1'b0, "R7 mid conversion");
    step(1, 1'b1, "R8 clear mid conversion");
    for (int i = 0; i < 3 * PERIOD + 6; i++) step(1, 1'b0, "R8 R5 negative clip");
    check(data_o === 24'h800000, "R5 negative limit", int'($signed(data_o)), -8388608);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule